// File: doc/BRIEF.md
# Stream Flusher with Framed Start and Stop

This block sits in a valid/ready data stream and can throw the stream away on demand. When the single flush-enable input asks for it, the block takes every beat the source offers, keeping its ready high even if the sink is stalled, and shows nothing to the sink. When no flush is in effect, valid, ready, data and the packet markers (start and end of packet) pass straight through.

Two parameters set where a flush may begin and end. One makes the start wait for a packet boundary: a packet already under way is sent to its end before discarding begins. The other makes the stop wait for a boundary: once the enable falls, discarding goes on until a start-of-packet beat arrives, and that beat is the first one forwarded. Without these options, both edges take effect in the same cycle as the enable changes.

The block also bridges ready latency. The source always sees a ready latency of zero. The sink may use zero or one. With one, the sink's ready is registered, and a beat is only presented in the cycle after the sink signalled ready.

Top module: `stream_flusher`

## Requirements
- R1: In a cycle where the block is discarding, a valid upstream beat is consumed and `dn_valid` stays 0.
- R2: While discarding, `up_ready` is 1 whatever the value of `dn_ready` (or of its registered copy).
- R3: With `FRAMED_START`=0, a beat offered in the first cycle that `flush_en` is 1 is already discarded.
- R4: With `FRAMED_START`=1, while a packet is open (a start-of-packet beat has been taken and its end-of-packet beat has not), beats keep passing even with `flush_en`=1. Discarding begins in the cycle after the end-of-packet beat is taken.
- R5: With `FRAMED_STOP`=0, forwarding resumes in the same cycle that `flush_en` is 0.
- R6: With `FRAMED_STOP`=1, discarding continues after `flush_en` falls until a start-of-packet beat is taken with `flush_en` low. That beat is forwarded with its data and marker. If it is offered while the sink is not ready, it waits rather than being dropped, and discarding stays in force.
- R7: When not discarding and `DN_RL`=0, `dn_valid` equals `up_valid`, `up_ready` equals `dn_ready`, and data, `sop` and `eop` are copied unchanged.
- R8: With `DN_RL`=1 and no discarding, `up_ready` and `dn_valid` (for a valid beat) equal the value `dn_ready` had in the previous cycle.
- R9: After reset the block forwards (no discarding, no open packet), and with `DN_RL`=1 the registered ready starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| flush_en | input | 1 | Request to discard the stream |
| up_valid | input | 1 | Source beat valid |
| up_ready | output | 1 | Ready toward the source (latency 0) |
| up_data | input | DATA_W | Source beat payload |
| up_sop | input | 1 | Source start-of-packet marker |
| up_eop | input | 1 | Source end-of-packet marker |
| dn_valid | output | 1 | Sink beat valid |
| dn_ready | input | 1 | Ready from the sink (latency DN_RL) |
| dn_data | output | DATA_W | Sink beat payload |
| dn_sop | output | 1 | Sink start-of-packet marker |
| dn_eop | output | 1 | Sink end-of-packet marker |

## Verification
The end of a framed flush and the forwarding of the beat that ends it happen in the same cycle. The bench offers a start-of-packet beat with the enable low and checks in that cycle that it appears at the sink with its payload. It first offers the same beat against a stalled sink and checks that it is held, not lost, and that a following ordinary beat is still discarded. Likewise, an end-of-packet beat that passes while the enable is already high must coincide with the last forwarded cycle. The bench checks that this beat is delivered and that the very next beat is discarded with ready high against a stalled sink.

// File: rtl/stream_flusher.sv
`timescale 1ns/1ps
module stream_flusher #(
  parameter int DATA_W       = 16,
  parameter bit FRAMED_START = 1'b1,
  parameter bit FRAMED_STOP  = 1'b1,
  parameter int DN_RL        = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_en,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_sop,
  input  logic              up_eop,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_sop,
  output logic              dn_eop
);

  logic flushing_q;
  logic in_pkt_q;
  logic path_rdy;
  logic drop;
  logic flush_nxt;
  logic take;
  logic sop_in;

  generate
    if (DN_RL == 1) begin : g_rl1
      logic rdy_q;
      always_ff @(posedge clk or posedge rst)
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= dn_ready;
      assign path_rdy = rdy_q;
    end else begin : g_rl0
      assign path_rdy = dn_ready;
    end
  endgenerate

  assign sop_in = up_valid && up_sop && !flush_en;

  always_comb begin
    if (flushing_q)
      drop = FRAMED_STOP ? !sop_in : flush_en;
    else
      drop = flush_en && (!FRAMED_START || !in_pkt_q);
    if (FRAMED_STOP && flushing_q)
      flush_nxt = !(sop_in && path_rdy);
    else
      flush_nxt = drop;
  end

  assign up_ready = drop ? 1'b1 : path_rdy;
  assign dn_valid = up_valid && !drop && ((DN_RL == 1) ? path_rdy : 1'b1);
  assign dn_data  = up_data;
  assign dn_sop   = up_sop;
  assign dn_eop   = up_eop;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      flushing_q <= 1'b0;
      in_pkt_q   <= 1'b0;
    end else begin
      flushing_q <= flush_nxt;
      if (take) begin
        if (up_eop)      in_pkt_q <= 1'b0;
        else if (up_sop) in_pkt_q <= 1'b1;
      end
    end
  end

  p_discard_r1: assert property (@(posedge clk) disable iff (rst)
    (flushing_q && flush_en && up_valid) |-> (up_ready && !dn_valid));

  p_ready_high_r2: assert property (@(posedge clk) disable iff (rst)
    (flushing_q && flush_en) |-> up_ready);

  p_immediate_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!FRAMED_START && flush_en && up_valid) |-> !dn_valid);

  p_tail_passes_r4: assert property (@(posedge clk) disable iff (rst)
    (FRAMED_START && DN_RL == 0 && !flushing_q && in_pkt_q && up_valid) |-> dn_valid);

  p_immediate_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (!FRAMED_STOP && DN_RL == 0 && !flush_en) |-> (dn_valid == up_valid && up_ready == dn_ready));

  p_hold_until_sop_r6: assert property (@(posedge clk) disable iff (rst)
    (FRAMED_STOP && flushing_q && up_valid && !up_sop) |-> !dn_valid);

  p_sop_forwarded_r6: assert property (@(posedge clk) disable iff (rst)
    (FRAMED_STOP && DN_RL == 0 && flushing_q && !flush_en && up_valid && up_sop) |-> dn_valid);

  p_latency_one_r8: assert property (@(posedge clk) disable iff (rst)
    (DN_RL == 1 && dn_valid) |-> $past(dn_ready));

endmodule

// File: tb/test_stream_flusher.sv
`timescale 1ns/1ps
module test_stream_flusher;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic a_en = 0, a_uv = 0, a_sop = 0, a_eop = 0, a_dr = 0;
  logic [DW-1:0] a_ud = '0;
  logic a_ur, a_dv, a_dsop, a_deop;
  logic [DW-1:0] a_dd;

  logic b_en = 0, b_uv = 0, b_sop = 0, b_eop = 0, b_dr = 0;
  logic [DW-1:0] b_ud = '0;
  logic b_ur, b_dv, b_dsop, b_deop;
  logic [DW-1:0] b_dd;

  logic c_en = 0, c_uv = 0, c_sop = 0, c_eop = 0, c_dr = 0;
  logic [DW-1:0] c_ud = '0;
  logic c_ur, c_dv, c_dsop, c_deop;
  logic [DW-1:0] c_dd;

  stream_flusher #(.DATA_W(DW), .FRAMED_START(1'b1), .FRAMED_STOP(1'b1), .DN_RL(0)) i_stream_flusher (
    .clk(clk), .rst(rst), .flush_en(a_en),
    .up_valid(a_uv), .up_ready(a_ur), .up_data(a_ud), .up_sop(a_sop), .up_eop(a_eop),
    .dn_valid(a_dv), .dn_ready(a_dr), .dn_data(a_dd), .dn_sop(a_dsop), .dn_eop(a_deop));

  stream_flusher #(.DATA_W(DW), .FRAMED_START(1'b0), .FRAMED_STOP(1'b0), .DN_RL(0)) i_stream_flusher_imm (
    .clk(clk), .rst(rst), .flush_en(b_en),
    .up_valid(b_uv), .up_ready(b_ur), .up_data(b_ud), .up_sop(b_sop), .up_eop(b_eop),
    .dn_valid(b_dv), .dn_ready(b_dr), .dn_data(b_dd), .dn_sop(b_dsop), .dn_eop(b_deop));

  stream_flusher #(.DATA_W(DW), .FRAMED_START(1'b0), .FRAMED_STOP(1'b0), .DN_RL(1)) i_stream_flusher_rl1 (
    .clk(clk), .rst(rst), .flush_en(c_en),
    .up_valid(c_uv), .up_ready(c_ur), .up_data(c_ud), .up_sop(c_sop), .up_eop(c_eop),
    .dn_valid(c_dv), .dn_ready(c_dr), .dn_data(c_dd), .dn_sop(c_dsop), .dn_eop(c_deop));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_a(input logic en, input logic v, input logic s, input logic e,
                         input logic [DW-1:0] d, input logic dr);
    @(negedge clk);
    a_en = en; a_uv = v; a_sop = s; a_eop = e; a_ud = d; a_dr = dr;
    #1;
  endtask

  task automatic drive_b(input logic en, input logic v, input logic s, input logic e,
                         input logic [DW-1:0] d, input logic dr);
    @(negedge clk);
    b_en = en; b_uv = v; b_sop = s; b_eop = e; b_ud = d; b_dr = dr;
    #1;
  endtask

  task automatic drive_c(input logic en, input logic v, input logic [DW-1:0] d, input logic dr);
    @(negedge clk);
    c_en = en; c_uv = v; c_sop = 1'b0; c_eop = 1'b0; c_ud = d; c_dr = dr;
    #1;
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b0;
    a_uv = 1; a_dr = 1; a_ud = 16'h1234;
    b_uv = 1; b_dr = 1; b_ud = 16'h0042;
    c_uv = 1; c_dr = 1; c_ud = 16'h0077;
    #1;
    chk("R9 a forwards after reset", a_dv, 1);
    chk("R9 a ready after reset", a_ur, 1);
    chk("R9 a data", a_dd, 16'h1234);
    chk("R9 b forwards after reset", b_dv, 1);
    chk("R9 c registered ready starts low", c_ur, 0);
    chk("R9 c no beat before ready", c_dv, 0);
    drive_c(0, 1, 16'h0078, 1);
    chk("R8 c ready one cycle later", c_ur, 1);
    chk("R8 c beat presented", c_dv, 1);
    drive_a(0, 0, 0, 0, 0, 0);
    drive_b(0, 0, 0, 0, 0, 0);
    drive_c(0, 0, 0, 0);
  endtask

  task automatic test_passthrough;
    for (int i = 0; i < 6; i++) begin
      logic dr;
      logic [DW-1:0] d;
      dr = logic'(i % 2);
      d = DW'(i * 37 + 5);
      drive_b(0, 1, i == 0, i == 5, d, dr);
      chk("R7 b valid copied", b_dv, 1);
      chk("R7 b ready copied", b_ur, dr);
      chk("R7 b data copied", b_dd, d);
      chk("R7 b sop copied", b_dsop, i == 0);
      chk("R7 b eop copied", b_deop, i == 5);
    end
    drive_b(0, 0, 0, 0, 0, 1);
    chk("R7 b idle gives no valid", b_dv, 0);
  endtask

  task automatic test_immediate;
    drive_b(1, 1, 0, 0, 16'h00aa, 0);
    chk("R3 b dropped in first enable cycle", b_dv, 0);
    chk("R2 b ready high while sink stalled", b_ur, 1);
    drive_b(1, 1, 1, 0, 16'h00ab, 1);
    chk("R1 b beat discarded", b_dv, 0);
    drive_b(0, 1, 0, 0, 16'h00ac, 0);
    chk("R5 b forwards in cycle enable falls", b_dv, 1);
    chk("R5 b ready follows sink", b_ur, 0);
    drive_b(0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_latency;
    logic prev;
    logic pat [5] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    drive_c(0, 1, 16'h0100, 1);
    prev = 1'b1;
    for (int i = 0; i < 5; i++) begin
      drive_c(0, 1, DW'(16'h0101 + i), pat[i]);
      chk("R8 c ready equals previous sink ready", c_ur, prev);
      chk("R8 c valid equals previous sink ready", c_dv, prev);
      prev = pat[i];
    end
    drive_c(1, 1, 16'h0200, 0);
    chk("R2 c ready high while flushing", c_ur, 1);
    chk("R1 c beat discarded", c_dv, 0);
    drive_c(0, 0, 0, 0);
  endtask

  task automatic test_framed_start;
    drive_a(0, 1, 1, 0, 16'h0a01, 1);
    chk("R4 a opening beat forwarded", a_dv, 1);
    drive_a(1, 1, 0, 0, 16'h0a02, 1);
    chk("R4 a mid packet passes with enable high", a_dv, 1);
    chk("R4 a mid packet data", a_dd, 16'h0a02);
    drive_a(1, 1, 0, 1, 16'h0a03, 1);
    chk("R4 a closing beat passes", a_dv, 1);
    chk("R4 a closing marker", a_deop, 1);
    drive_a(1, 1, 0, 0, 16'h0a04, 0);
    chk("R4 a discarding after packet end", a_dv, 0);
    chk("R2 a ready high against stalled sink", a_ur, 1);
  endtask

  task automatic test_framed_stop;
    drive_a(0, 1, 0, 0, 16'h0b01, 1);
    chk("R6 a non-sop beat still discarded", a_dv, 0);
    chk("R6 a ready high while discarding", a_ur, 1);
    drive_a(0, 0, 0, 0, 0, 0);
    chk("R6 a idle still discarding keeps ready", a_ur, 1);
    drive_a(0, 1, 1, 0, 16'h0b02, 0);
    chk("R6 a sop held for stalled sink", a_ur, 0);
    drive_a(0, 1, 0, 0, 16'h0b03, 0);
    chk("R6 a still discarding after unaccepted sop", a_dv, 0);
    drive_a(0, 1, 1, 0, 16'h0b04, 1);
    chk("R6 a sop ends flush and is forwarded", a_dv, 1);
    chk("R6 a sop marker forwarded", a_dsop, 1);
    chk("R6 a sop data forwarded", a_dd, 16'h0b04);
    drive_a(0, 1, 0, 0, 16'h0b05, 0);
    chk("R7 a forwarding after flush", a_dv, 1);
    chk("R7 a ready follows sink", a_ur, 0);
    drive_a(0, 1, 0, 1, 16'h0b06, 1);
    chk("R7 a eop forwarded", a_deop, 1);
    drive_a(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_passthrough();
    test_immediate();
    test_latency();
    test_framed_start();
    test_framed_stop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule